// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block keeps the pending-interrupt flags and the per-source enable mask of a parallel I/O adapter, and drives one level-sensitive interrupt request toward the processor. There are seven sources: timer 1, timer 2, the shift register and four handshake lines. Each source delivers one-cycle set pulses. Other parts of the adapter deliver one-cycle clear pulses when the processor touches the registers that belong to those sources.

The processor reaches the block through a 4-bit register offset with a write strobe and write data, and reads back through a combinational read port. Offset 0xD is the flag register and offset 0xE is the enable register. The block also watches writes to the port data offsets, 0x0 and 0x1, because those writes acknowledge the handshake flags. Writes to the no-handshake port A alias, 0xF, acknowledge nothing.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, every flag and every enable bit is 0, `irq_o` is low, a read at 0xD returns 0x00 and a read at 0xE returns 0x80.
- R2: A write to 0xE with data bit 7 = 1 sets each enable bit whose data bit (6:0) is 1 and leaves the other enable bits unchanged.
- R3: A write to 0xE with data bit 7 = 0 clears each enable bit whose data bit (6:0) is 1 and leaves the other enable bits unchanged.
- R4: A read at 0xE returns 1 in bit 7 and the enable bits in bits 6:0.
- R5: A write to 0xD clears each flag whose data bit (6:0) is 1 and leaves the other flags unchanged. Data bit 7 is ignored.
- R6: `irq_o` is high exactly while some flag is set with its enable bit set, and it follows the registered state with no further delay. A read at 0xD returns `irq_o` in bit 7 and the flags in bits 6:0.
- R7: A write to 0x0 (port B data) clears flags 4 and 3, and leaves the other flags unchanged. A write to 0x1 (port A data) clears flags 1 and 0, and leaves the other flags unchanged.
- R8: A write to 0xF (port A alias) changes no flag.
- R9: If a set pulse and any clear (a clear pulse, a flag write or a port write) reach the same flag in the same cycle, the flag ends up set.
- R10: A set pulse on `set_pulse_i[k]` sets flag k whatever the state of enable bit k. The flag bits are: 6 timer 1, 5 timer 2, 4 port B line 1, 3 port B line 2, 2 shift register, 1 port A line 1, 0 port A line 2.
- R11: A clear pulse on `clr_pulse_i[k]` clears flag k when no set pulse reaches flag k in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 4 | Register offset |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for 0xD and 0xE; 0 for other offsets |
| set_pulse_i | input | 7 | Per-source set pulses |
| clr_pulse_i | input | 7 | Per-source clear pulses from other register accesses |
| irq_o | output | 1 | Interrupt request, active high, level |

## Verification
The bench builds the block with its default 8-bit data path, which gives seven sources. At that size every enable write value, all 256 of them, can be applied in turn against the running mask. Every pair of flag pattern and flag-clear mask, 128 × 128, can also be covered, so every mix of cleared, kept, enabled and disabled bits appears. Port writes, alias writes, clear pulses and set-versus-clear collisions are each swept over all 128 flag patterns.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFF_PORTB    = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_PORTA    = 4'h1;
  localparam logic [ADDR_W-1:0] OFF_FLAG     = 4'hD;
  localparam logic [ADDR_W-1:0] OFF_ENABLE   = 4'hE;
  localparam logic [ADDR_W-1:0] OFF_PORTA_NH = 4'hF;

  // source positions, shared with the neighbours that raise the pulses
  localparam int unsigned SRC_TMR1   = 6;
  localparam int unsigned SRC_TMR2   = 5;
  localparam int unsigned SRC_PB_L1  = 4;
  localparam int unsigned SRC_PB_L2  = 3;
  localparam int unsigned SRC_SHIFT  = 2;
  localparam int unsigned SRC_PA_L1  = 1;
  localparam int unsigned SRC_PA_L2  = 0;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NSRC = DATA_W - 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NSRC-1:0]   flag_clr_o,
  output logic [NSRC-1:0]   en_set_o,
  output logic [NSRC-1:0]   en_clr_o
);
  logic [NSRC-1:0] pb_mask, pa_mask, wmask;
  logic            wr_flag, wr_en, wr_pb, wr_pa;

  always_comb begin
    pb_mask = '0;
    pa_mask = '0;
    pb_mask[SRC_PB_L1] = 1'b1;
    pb_mask[SRC_PB_L2] = 1'b1;
    pa_mask[SRC_PA_L1] = 1'b1;
    pa_mask[SRC_PA_L2] = 1'b1;
  end

  assign wmask   = wdata_i[NSRC-1:0];
  assign wr_flag = we_i && (addr_i == OFF_FLAG);
  assign wr_en   = we_i && (addr_i == OFF_ENABLE);
  assign wr_pb   = we_i && (addr_i == OFF_PORTB);
  assign wr_pa   = we_i && (addr_i == OFF_PORTA);
  // the no-handshake alias is decoded nowhere: it must not acknowledge

  assign flag_clr_o = (wr_flag ? wmask : '0)
                    | (wr_pb ? pb_mask : '0)
                    | (wr_pa ? pa_mask : '0);
  assign en_set_o = (wr_en &&  wdata_i[DATA_W-1]) ? wmask : '0;
  assign en_clr_o = (wr_en && !wdata_i[DATA_W-1]) ? wmask : '0;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned NSRC = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] flag_o
);
  for (genvar k = 0; k < NSRC; k++) begin : g_cell
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          q <= 1'b0;
      else if (set_i[k])    q <= 1'b1;   // set beats any clear
      else if (clr_i[k])    q <= 1'b0;
    end
    assign flag_o[k] = q;
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned NSRC = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] en_o
);
  logic [NSRC-1:0] en_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= (en_q | set_i) & ~clr_i;
  end
  assign en_o = en_q;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NSRC = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [NSRC-1:0]   set_pulse_i,
  input  logic [NSRC-1:0]   clr_pulse_i,
  output logic              irq_o
);
  logic [NSRC-1:0] bus_flag_clr, en_set, en_clr, flag_vec, en_vec;

  irq_bus_decode #(.DATA_W(DATA_W)) u_dec (
    .addr_i     (bus_addr_i),
    .we_i       (bus_we_i),
    .wdata_i    (bus_wdata_i),
    .flag_clr_o (bus_flag_clr),
    .en_set_o   (en_set),
    .en_clr_o   (en_clr)
  );

  irq_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_pulse_i),
    .clr_i  (clr_pulse_i | bus_flag_clr),
    .flag_o (flag_vec)
  );

  irq_enable_reg #(.NSRC(NSRC)) u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (en_set),
    .clr_i  (en_clr),
    .en_o   (en_vec)
  );

  assign irq_o = |(flag_vec & en_vec);

  always_comb begin
    unique case (bus_addr_i)
      OFF_FLAG:   bus_rdata_o = {irq_o, flag_vec};
      OFF_ENABLE: bus_rdata_o = {1'b1, en_vec};
      default:    bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk
  import irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned NSRC = DATA_W - 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_we_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic [NSRC-1:0]   set_pulse_i,
  input logic [NSRC-1:0]   clr_pulse_i,
  input logic [NSRC-1:0]   flag_vec,
  input logic [NSRC-1:0]   en_vec,
  input logic              irq_o
);
  assert_en_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFF_ENABLE && bus_wdata_i[DATA_W-1])
    |=> ((en_vec & $past(bus_wdata_i[NSRC-1:0])) == $past(bus_wdata_i[NSRC-1:0])));

  assert_en_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFF_ENABLE && !bus_wdata_i[DATA_W-1])
    |=> ((en_vec & $past(bus_wdata_i[NSRC-1:0])) == '0));

  assert_en_read_top_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == OFF_ENABLE) |-> bus_rdata_o[DATA_W-1]);

  assert_flag_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFF_FLAG)
    |=> ((flag_vec & $past(bus_wdata_i[NSRC-1:0] & ~set_pulse_i)) == '0));

  assert_irq_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFF_FLAG && (&bus_wdata_i[NSRC-1:0]) && set_pulse_i == '0)
    |=> !irq_o);

  assert_portb_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFF_PORTB && !set_pulse_i[SRC_PB_L1] && !set_pulse_i[SRC_PB_L2])
    |=> (!flag_vec[SRC_PB_L1] && !flag_vec[SRC_PB_L2]));

  assert_alias_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFF_PORTA_NH && clr_pulse_i == '0)
    |=> ((flag_vec & $past(flag_vec)) == $past(flag_vec)));

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_pulse_i != '0) |=> ((flag_vec & $past(set_pulse_i)) == $past(set_pulse_i)));

  assert_pulse_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pulse_i != '0)
    |=> ((flag_vec & $past(clr_pulse_i & ~set_pulse_i)) == '0));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_we_i    (bus_we_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .set_pulse_i (set_pulse_i),
  .clr_pulse_i (clr_pulse_i),
  .flag_vec    (flag_vec),
  .en_vec      (en_vec),
  .irq_o       (irq_o)
);

// File: tb/irq_flag_ctrl_test.sv
`timescale 1ns/1ps
module irq_flag_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = 4'h2;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [6:0] set_p = '0;
  logic [6:0] clr_p = '0;
  logic       irq;

  int total = 0;
  int bad = 0;
  logic [6:0] m_flag = '0;
  logic [6:0] m_en = '0;

  always #10 clk = ~clk;

  irq_flag_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_we_i(bus_we),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .set_pulse_i(set_p),
    .clr_pulse_i(clr_p), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  // one cycle with bus write plus pulses, model updated from requirements
  task automatic step(input logic we, input logic [3:0] a, input logic [7:0] d,
                      input logic [6:0] s, input logic [6:0] c);
    logic [6:0] clr_all;
    bus_we = we; bus_addr = a; bus_wdata = d; set_p = s; clr_p = c;
    @(negedge clk);
    bus_we = 1'b0; set_p = '0; clr_p = '0;
    clr_all = c;
    if (we && a == 4'hD) clr_all |= d[6:0];
    if (we && a == 4'h0) clr_all |= 7'b0011000;
    if (we && a == 4'h1) clr_all |= 7'b0000011;
    if (we && a == 4'hE) m_en = d[7] ? (m_en | d[6:0]) : (m_en & ~d[6:0]);
    m_flag = s | (m_flag & ~clr_all);
  endtask

  task automatic check_state(input string req);
    logic [7:0] d;
    rd(4'hD, d);
    chk(req, d, {|(m_flag & m_en), m_flag});
    chk(req, {7'd0, irq}, {7'd0, |(m_flag & m_en)});
  endtask

  initial begin
    logic [7:0] d;
    #35 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'hD, d); chk("R1 flag reg", d, 8'h00);
    rd(4'hE, d); chk("R1 enable reg", d, 8'h80);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R2 R3 R4: every enable write value
    for (int v = 0; v < 256; v++) begin
      step(1'b1, 4'hE, v[7:0], '0, '0);
      rd(4'hE, d);
      chk(v[7] ? "R2 R4 enable set" : "R3 R4 enable clear", d, {1'b1, m_en});
    end

    // R5 R6 R10: all flag patterns against all clear masks, enables 0x55
    step(1'b1, 4'hE, 8'h7F, '0, '0);
    step(1'b1, 4'hE, 8'hD5, '0, '0);
    for (int v = 0; v < 128; v++) begin
      for (int m = 0; m < 128; m++) begin
        step(1'b1, 4'hD, 8'hFF, '0, '0);
        step(1'b0, 4'h2, 8'h00, v[6:0], '0);
        if (m == 0) check_state("R10 R6 set pulse");
        step(1'b1, 4'hD, {m[0], m[6:0]}, '0, '0);
        check_state("R5 R6 flag clear");
      end
    end

    // R7 R8: port writes and alias over all flag patterns
    for (int v = 0; v < 128; v++) begin
      step(1'b0, 4'h2, 8'h00, v[6:0], '0);
      step(1'b1, 4'hF, 8'hFF, '0, '0);
      check_state("R8 alias no clear");
      step(1'b1, 4'h0, 8'hA5, '0, '0);
      check_state("R7 port B ack");
      step(1'b0, 4'h2, 8'h00, v[6:0], '0);
      step(1'b1, 4'h1, 8'h5A, '0, '0);
      check_state("R7 port A ack");
      step(1'b1, 4'hD, 8'h7F, '0, '0);
    end

    // R9 R11: collisions and clear pulses
    for (int v = 0; v < 128; v++) begin
      step(1'b0, 4'h2, 8'h00, 7'h7F, '0);
      step(1'b1, 4'hD, 8'h7F, v[6:0], 7'h7F);
      check_state("R9 set wins");
      step(1'b1, 4'h1, 8'h00, 7'h7F, '0);
      check_state("R9 set wins over port ack");
      step(1'b0, 4'h2, 8'h00, '0, v[6:0]);
      check_state("R11 clear pulse");
      step(1'b1, 4'hD, 8'h7F, '0, '0);
    end

    // R6: level follows disabling
    step(1'b1, 4'hE, 8'hFF, 7'h40, '0);
    check_state("R6 irq raised");
    step(1'b1, 4'hE, 8'h40, '0, '0);
    check_state("R6 irq dropped by disable");
    chk("R6 irq low", {7'd0, irq}, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule